// File: doc/BRIEF.md
# DMA Dispatcher Control and Status Registers

This block is the software-facing register front end of a descriptor-driven DMA engine. The block has five 32-bit registers at word-aligned byte offsets. Software uses them to start and stop the engine, to ask for an engine reset and to choose whether the engine halts on an error or an early-termination event. It also reads back FIFO flags, fill levels and sequence numbers that the engine supplies. The block combines completion, error and early-termination pulses from the engine into a single interrupt line.

An engine reset is a timed handshake. A control write with the reset bit set moves a small state machine from `RST_IDLE` to `RST_ACTIVE` (transition START). The machine stays in `RST_ACTIVE` for a parameterised number of cycles and then returns to `RST_IDLE` (transition FINISH). During `RST_ACTIVE`, a status bit and the engine reset output stay high, control writes and engine pulses are ignored, and at FINISH the control register and all sticky status bits are cleared. Software polls the status bit until it drops.

Top module: `dma_csr_regs`

## Requirements
- R1: After rst_n is released, the control register reads 0, the sticky status bits (bits 5 to 9) read 0, and eng_stop, eng_reset and irq are low.
- R2: Reads are combinational on reg_addr[4:2]. Offset 0x00 returns status, 0x04 control, 0x08 {wr_fill, rd_fill}, 0x0C {16'b0, resp_fill} and 0x10 {wr_seq, rd_seq}; any other offset reads 0.
- R3: Outside a reset sequence, a write to 0x04 stores bits 5:0 in the control register. The bit meanings are 0 stop, 1 reset request, 2 halt on error, 3 halt on early termination, 4 interrupt enable and 5 halt descriptor fetch. The value reads back with bits 31:6 at zero, and bits 2, 3 and 5 drive their outputs.
- R4: In the status register, bit 0 is busy, bit 1 descriptor FIFO empty, bit 2 descriptor FIFO full, bit 3 response FIFO empty and bit 4 response FIFO full, each copied from its input in the same cycle.
- R5: A control write with bit 1 set makes status bit 6 and eng_reset high, starting the next cycle, for exactly RST_CYCLES cycles (default 16). After that the control register reads 0.
- R6: While status bit 6 is high, writes to the control register have no effect.
- R7: Status bit 9 (IRQ) is set by a done, error or early pulse. Writing 1 to bit 9 of 0x00 clears it. A set in the same cycle as a clear wins.
- R8: The irq output equals status bit 9 AND control bit 4.
- R9: An error pulse while control bit 2 is set latches status bit 7. Status bit 5 and eng_stop then stay high until software writes 1 to bit 7. With control bit 2 clear, an error pulse latches nothing.
- R10: An early pulse while control bit 3 is set latches status bit 8, with the same effect on bit 5 and eng_stop. Writing 1 to bit 8 clears it.
- R11: Engine pulses arriving during a reset sequence are ignored. Bits 7, 8 and 9 are cleared when the sequence ends.
- R12: Writes to offsets 0x08, 0x0C and 0x10 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| eng_busy | input | 1 | Engine is moving data |
| desc_empty | input | 1 | Descriptor FIFO empty |
| desc_full | input | 1 | Descriptor FIFO full |
| resp_empty | input | 1 | Response FIFO empty |
| resp_full | input | 1 | Response FIFO full |
| done_pulse | input | 1 | One-cycle transfer completion |
| err_pulse | input | 1 | One-cycle transfer error |
| early_pulse | input | 1 | One-cycle early termination |
| rd_fill | input | 16 | Read descriptor fill level |
| wr_fill | input | 16 | Write descriptor fill level |
| resp_fill | input | 16 | Response FIFO fill level |
| rd_seq | input | 16 | Read sequence number |
| wr_seq | input | 16 | Write sequence number |
| eng_stop | output | 1 | Engine must stop |
| eng_reset | output | 1 | Engine reset in progress |
| eng_halt_err_en | output | 1 | Halt-on-error option |
| eng_halt_early_en | output | 1 | Halt-on-early-termination option |
| eng_halt_desc | output | 1 | Stop descriptor fetching |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, several cycle-local rules:
- a pulse sets the IRQ flag;
- an enabled error latches its halt bit;
- the sticky bits and the control register stay frozen while a reset runs;
- the reset counter stays within bounds;
- control returns to zero right after FINISH.

Only the bench scenarios can show the cases that span a sequence of events:
- the exact length of the reset window as seen at the ports;
- set-over-clear priority when software and engine collide;
- the release of eng_stop after a write-1-to-clear;
- the absence of any effect from writes to the read-only offsets.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
    typedef enum logic [0:0] {
        RST_IDLE   = 1'b0,
        RST_ACTIVE = 1'b1
    } rst_state_e;

    // word index = byte offset / 4
    localparam int unsigned W_STATUS  = 0;
    localparam int unsigned W_CONTROL = 1;
    localparam int unsigned W_LEVELS  = 2;
    localparam int unsigned W_RESP    = 3;
    localparam int unsigned W_SEQ     = 4;

    localparam int unsigned CTL_W = 6;

    typedef struct packed {
        logic halt_desc;   // bit 5
        logic irq_en;      // bit 4
        logic early_en;    // bit 3
        logic err_en;      // bit 2
        logic rst_req;     // bit 1
        logic stop;        // bit 0
    } ctl_t;
endpackage

// File: rtl/dcsr_rst_seq.sv
module dcsr_rst_seq
    import dcsr_pkg::*;
#(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic finish
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    rst_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RST_IDLE: begin
                if (start) begin          // START
                    state_d = RST_ACTIVE;
                    cnt_d   = CW'(CYCLES - 1);
                end
            end
            RST_ACTIVE: begin
                if (cnt_q == '0) begin    // FINISH
                    state_d = RST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = RST_IDLE;
        endcase
    end

    always_comb begin
        active = (state_q == RST_ACTIVE);
        finish = (state_q == RST_ACTIVE) && (cnt_q == '0);
    end

    // R5
    rst_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < CW'(CYCLES)));

    // R5
    rst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !finish) |=> active);
endmodule

// File: rtl/dcsr_flags.sv
module dcsr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic wipe,
    input  logic done_p,
    input  logic err_p,
    input  logic early_p,
    input  logic err_en,
    input  logic early_en,
    input  logic clr_irq,
    input  logic clr_err,
    input  logic clr_early,
    output logic irq_flag,
    output logic halt_err,
    output logic halt_early
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_flag   <= 1'b0;
            halt_err   <= 1'b0;
            halt_early <= 1'b0;
        end else if (wipe) begin
            irq_flag   <= 1'b0;
            halt_err   <= 1'b0;
            halt_early <= 1'b0;
        end else if (!hold) begin
            if (done_p || err_p || early_p) irq_flag <= 1'b1;
            else if (clr_irq)               irq_flag <= 1'b0;
            if (err_p && err_en)            halt_err <= 1'b1;
            else if (clr_err)               halt_err <= 1'b0;
            if (early_p && early_en)        halt_early <= 1'b1;
            else if (clr_early)             halt_early <= 1'b0;
        end
    end

    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && (done_p || err_p || early_p)) |=> irq_flag);

    // R9
    err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && err_p && err_en) |=> halt_err);

    // R10
    early_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && early_p && early_en) |=> halt_early);

    // R11
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !wipe) |=> $stable({irq_flag, halt_err, halt_early}));
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
    import dcsr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LVL_W      = 16,
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_busy,
    input  logic              desc_empty,
    input  logic              desc_full,
    input  logic              resp_empty,
    input  logic              resp_full,
    input  logic              done_pulse,
    input  logic              err_pulse,
    input  logic              early_pulse,
    input  logic [LVL_W-1:0]  rd_fill,
    input  logic [LVL_W-1:0]  wr_fill,
    input  logic [LVL_W-1:0]  resp_fill,
    input  logic [LVL_W-1:0]  rd_seq,
    input  logic [LVL_W-1:0]  wr_seq,
    output logic              eng_stop,
    output logic              eng_reset,
    output logic              eng_halt_err_en,
    output logic              eng_halt_early_en,
    output logic              eng_halt_desc,
    output logic              irq
);
    localparam int unsigned WA_W   = ADDR_W - 2;
    localparam int unsigned STAT_W = 10;

    logic [WA_W-1:0] word;
    logic            wr_ctl, wr_stat, rst_active, rst_finish;
    logic            irq_flag, halt_err, halt_early, stopped;
    ctl_t            ctl_q;
    logic [STAT_W-1:0] stat_vec;

    assign word    = reg_addr[ADDR_W-1:2];
    assign wr_ctl  = reg_wr && (word == WA_W'(W_CONTROL)) && !rst_active;
    assign wr_stat = reg_wr && (word == WA_W'(W_STATUS));

    dcsr_rst_seq #(.CYCLES(RST_CYCLES)) u_rst_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_ctl && reg_wdata[1]),
        .active (rst_active),
        .finish (rst_finish)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ctl_q <= '0;
        else if (rst_finish) ctl_q <= '0;
        else if (wr_ctl)     ctl_q <= ctl_t'(reg_wdata[CTL_W-1:0]);
    end

    dcsr_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (rst_active),
        .wipe       (rst_finish),
        .done_p     (done_pulse),
        .err_p      (err_pulse),
        .early_p    (early_pulse),
        .err_en     (ctl_q.err_en),
        .early_en   (ctl_q.early_en),
        .clr_irq    (wr_stat && reg_wdata[9]),
        .clr_err    (wr_stat && reg_wdata[7]),
        .clr_early  (wr_stat && reg_wdata[8]),
        .irq_flag   (irq_flag),
        .halt_err   (halt_err),
        .halt_early (halt_early)
    );

    assign stopped  = ctl_q.stop || halt_err || halt_early;
    assign stat_vec = {irq_flag, halt_early, halt_err, rst_active, stopped,
                       resp_full, resp_empty, desc_full, desc_empty, eng_busy};

    always_comb begin
        reg_rdata = '0;
        case (word)
            WA_W'(W_STATUS):  reg_rdata = DATA_W'(stat_vec);
            WA_W'(W_CONTROL): reg_rdata = DATA_W'(ctl_q);
            WA_W'(W_LEVELS):  reg_rdata = DATA_W'({wr_fill, rd_fill});
            WA_W'(W_RESP):    reg_rdata = DATA_W'(resp_fill);
            WA_W'(W_SEQ):     reg_rdata = DATA_W'({wr_seq, rd_seq});
            default:          reg_rdata = '0;
        endcase
    end

    assign eng_stop          = stopped;
    assign eng_reset         = rst_active;
    assign eng_halt_err_en   = ctl_q.err_en;
    assign eng_halt_early_en = ctl_q.early_en;
    assign eng_halt_desc     = ctl_q.halt_desc;
    assign irq               = irq_flag && ctl_q.irq_en;

    // R6
    ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_active && !rst_finish) |=> $stable(ctl_q));

    // R5
    ctl_zero_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_finish |=> (ctl_q == '0 && !eng_reset));

    // R9
    stop_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_err && !rst_active && !(wr_stat && reg_wdata[7])) |=> eng_stop);
endmodule

// File: tb/dma_csr_regs_tb.sv
module dma_csr_regs_tb;
    localparam int RST_N_CYC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_busy = 0, desc_empty = 1, desc_full = 0, resp_empty = 1, resp_full = 0;
    logic        done_pulse = 0, err_pulse = 0, early_pulse = 0;
    logic [15:0] rd_fill = 0, wr_fill = 0, resp_fill = 0, rd_seq = 0, wr_seq = 0;
    logic        eng_stop, eng_reset, eng_halt_err_en, eng_halt_early_en, eng_halt_desc, irq;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [5:0] m_ctl = '0;
    logic       m_irq = 0, m_herr = 0, m_hearly = 0;
    int         m_left = 0;

    always #5 clk = ~clk;

    dma_csr_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
        .desc_empty(desc_empty), .desc_full(desc_full), .resp_empty(resp_empty),
        .resp_full(resp_full), .done_pulse(done_pulse), .err_pulse(err_pulse),
        .early_pulse(early_pulse), .rd_fill(rd_fill), .wr_fill(wr_fill),
        .resp_fill(resp_fill), .rd_seq(rd_seq), .wr_seq(wr_seq),
        .eng_stop(eng_stop), .eng_reset(eng_reset), .eng_halt_err_en(eng_halt_err_en),
        .eng_halt_early_en(eng_halt_early_en), .eng_halt_desc(eng_halt_desc), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic m_stopped();
        return m_ctl[0] | m_herr | m_hearly;
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [4:0] a);
        case (a[4:2])
            3'd0: return {22'd0, m_irq, m_hearly, m_herr, (m_left != 0), m_stopped(),
                          resp_full, resp_empty, desc_full, desc_empty, eng_busy};
            3'd1: return {26'd0, m_ctl};
            3'd2: return {wr_fill, rd_fill};
            3'd3: return {16'd0, resp_fill};
            3'd4: return {wr_seq, rd_seq};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_edge();
        logic st;
        if (m_left != 0) begin
            if (m_left == 1) begin
                m_ctl = '0; m_irq = 0; m_herr = 0; m_hearly = 0;
            end
            m_left--;
        end else begin
            st = reg_wr && (reg_addr[4:2] == 3'd0);
            if (done_pulse || err_pulse || early_pulse) m_irq = 1;
            else if (st && reg_wdata[9])                m_irq = 0;
            if (err_pulse && m_ctl[2])                  m_herr = 1;
            else if (st && reg_wdata[7])                m_herr = 0;
            if (early_pulse && m_ctl[3])                m_hearly = 1;
            else if (st && reg_wdata[8])                m_hearly = 0;
            if (reg_wr && reg_addr[4:2] == 3'd1) begin
                m_ctl = reg_wdata[5:0];
                if (reg_wdata[1]) m_left = RST_N_CYC;
            end
        end
    endtask

    task automatic compare_all();
        string rtag;
        case (reg_addr[4:2])
            3'd0: rtag = "R4 status read";
            3'd1: rtag = "R3 control read";
            3'd2: rtag = "R2 R12 level read";
            default: rtag = "R2 read";
        endcase
        check(rtag, reg_rdata, exp_rdata(reg_addr));
        check("R3 option outputs", {29'd0, eng_halt_desc, eng_halt_early_en, eng_halt_err_en},
              {29'd0, m_ctl[5], m_ctl[3], m_ctl[2]});
        check("R5 eng_reset", {31'd0, eng_reset}, {31'd0, m_left != 0});
        check("R8 irq", {31'd0, irq}, {31'd0, m_irq & m_ctl[4]});
        check("R9 eng_stop", {31'd0, eng_stop}, {31'd0, m_stopped()});
    endtask

    task automatic step(input logic wr, input logic [4:0] a, input logic [31:0] d,
                        input logic dn, input logic er, input logic ea);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        done_pulse = dn; err_pulse = er; early_pulse = ea;
        eng_busy = 1'($urandom); desc_empty = 1'($urandom); desc_full = 1'($urandom);
        resp_empty = 1'($urandom); resp_full = 1'($urandom);
        rd_fill = 16'($urandom); wr_fill = 16'($urandom); resp_fill = 16'($urandom);
        rd_seq = 16'($urandom); wr_seq = 16'($urandom);
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
    endtask

    task automatic idle(input logic [4:0] a);
        step(1'b0, a, 32'd0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int rcount;
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 control after reset", reg_rdata & 32'h0, 32'h0);
        reg_addr = 5'h04; #1;
        check("R1 control after reset", reg_rdata, 32'h0);
        reg_addr = 5'h00; #1;
        check("R1 sticky status after reset", reg_rdata & 32'h3E0, 32'h0);
        check("R1 outputs after reset", {29'd0, eng_stop, eng_reset, irq}, 32'h0);

        // R5 reset sequence length; R6 write ignored; R11 pulse ignored
        step(1'b1, 5'h04, 32'h0000_0016, 1'b0, 1'b0, 1'b0);
        rcount = 0;
        if (eng_reset) rcount++;
        step(1'b1, 5'h04, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
        if (eng_reset) rcount++;
        check("R6 control write during reset", {31'd0, eng_stop}, 32'h0);
        step(1'b0, 5'h00, 32'h0, 1'b1, 1'b1, 1'b1);
        if (eng_reset) rcount++;
        check("R11 pulse during reset", reg_rdata & 32'h200, 32'h0);
        for (int i = 0; i < 30; i++) begin
            idle(5'h00);
            if (eng_reset) rcount++;
        end
        check("R5 reset window length", rcount, RST_N_CYC);
        idle(5'h04);
        check("R5 control zero after reset", reg_rdata, 32'h0);

        // R7 and R8
        step(1'b1, 5'h04, 32'h0000_0010, 1'b0, 1'b0, 1'b0);
        step(1'b0, 5'h00, 32'h0, 1'b1, 1'b0, 1'b0);
        check("R8 irq after done", {31'd0, irq}, 32'h1);
        step(1'b1, 5'h00, 32'h0000_0200, 1'b1, 1'b0, 1'b0);
        check("R7 set wins over clear", reg_rdata & 32'h200, 32'h200);
        step(1'b1, 5'h00, 32'h0000_0200, 1'b0, 1'b0, 1'b0);
        check("R7 write-1 clears", reg_rdata & 32'h200, 32'h0);

        // R9
        step(1'b1, 5'h04, 32'h0000_0004, 1'b0, 1'b0, 1'b0);
        step(1'b0, 5'h00, 32'h0, 1'b0, 1'b1, 1'b0);
        check("R9 stop on error bits 5,7", reg_rdata & 32'h0A0, 32'h0A0);
        check("R9 eng_stop raised", {31'd0, eng_stop}, 32'h1);
        idle(5'h00);
        check("R9 eng_stop held", {31'd0, eng_stop}, 32'h1);
        step(1'b1, 5'h00, 32'h0000_0080, 1'b0, 1'b0, 1'b0);
        check("R9 cleared by write-1", {31'd0, eng_stop}, 32'h0);
        step(1'b1, 5'h04, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
        step(1'b0, 5'h00, 32'h0, 1'b0, 1'b1, 1'b0);
        check("R9 no latch when disabled", reg_rdata & 32'h0A0, 32'h0);

        // R10
        step(1'b1, 5'h04, 32'h0000_0008, 1'b0, 1'b0, 1'b0);
        step(1'b0, 5'h00, 32'h0, 1'b0, 1'b0, 1'b1);
        check("R10 stop on early bits 5,8", reg_rdata & 32'h120, 32'h120);
        step(1'b1, 5'h00, 32'h0000_0100, 1'b0, 1'b0, 1'b0);
        check("R10 cleared by write-1", reg_rdata & 32'h120, 32'h0);

        // R11 wipe at end of reset
        step(1'b1, 5'h04, 32'h0000_0004, 1'b0, 1'b0, 1'b0);
        step(1'b0, 5'h00, 32'h0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 5'h04, 32'h0000_0002, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < RST_N_CYC + 2; i++) idle(5'h00);
        check("R11 sticky bits wiped", reg_rdata & 32'h3A0, 32'h0);

        // R12 and R2
        step(1'b1, 5'h08, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        idle(5'h08);
        check("R12 level register unchanged", reg_rdata, {wr_fill, rd_fill});
        step(1'b1, 5'h10, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        check("R12 sequence register unchanged", reg_rdata, {wr_seq, rd_seq});
        idle(5'h0C);
        check("R2 response fill", reg_rdata, {16'd0, resp_fill});
        idle(5'h14);
        check("R2 unmapped offset", reg_rdata, 32'h0);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [4:0]  a;
            logic [31:0] d;
            logic        w;
            w = ($urandom % 4) == 0;
            a = 5'({$urandom % 6, 2'b00});
            d = $urandom;
            if (a == 5'h04 && ($urandom % 8) != 0) d[1] = 1'b0;
            step(w, a, d, ($urandom % 6) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule